// File: doc/BRIEF.md
# Depth-Stencil Pack and Unpack Engine

This block moves pixels between a packed depth-stencil stream and two separately stored surfaces. Depth values sit in a surface laid out in 4 KiB Y-major tiles. Stencil values sit in their own one-byte-per-pixel surface laid out in 4 KiB W-major tiles. Each surface has its own base address and its own count of tiles per row. In read mode the engine fetches the depth word and the stencil byte of each pixel and merges them into one packed pixel on the stream. In write mode it takes packed pixels from the stream, splits them, and issues one depth write and one stencil write per pixel.

A job is started with a pulse on `start`, together with the direction, the format, the rectangle size and the surface parameters. Pixels are walked in raster order, left to right and then top to bottom. Every stream pixel also carries its byte offset in a linear packed buffer. Rows in that buffer begin on 64-byte boundaries. A stencil-only format moves single stencil bytes and never touches the depth surface. `done` pulses once when the last pixel of the job has completed.

Top module: `dsp_pack_engine`

## Requirements
- R1: Read, format code 0 (24-bit depth): `out_data` = {32'h0, stencil byte, depth word bits [23:0]}.
- R2: Read, format code 1 (32-bit float depth): `out_data` = {24'h0, stencil byte, full 32-bit depth word}. Bytes 5 to 7 are zero.
- R3: Write, format code 0: the depth write carries {8'h00, in_data[23:0]} with byte enables 4'b0111. The stencil write carries in_data[31:24].
- R4: Write, format code 1: the depth write carries in_data[31:0] with byte enables 4'b1111. The stencil write carries in_data[39:32].
- R5: Format code 2 (stencil only; code 3 behaves the same): no depth request is ever issued. The stencil byte travels in bits [7:0] of the stream, and bits [63:8] read as zero.
- R6: Depth address = depth base + Y-major tiled offset of (xb = 4*col, y = row). That offset is ((y/32)*tpr + xb/128)*4096 + ((xb%128)/16)*512 + (y%32)*16 + xb%16, where tpr is the depth tiles per row.
- R7: Stencil address = stencil base + W-major tiled offset of (x = col, y = row). That offset is ((y/64)*tpr + x/64)*4096 + ((x%64)/8)*512 + ((y%64)/8)*64, plus bit 2, 1 and 0 of y at weights 32, 8, 2 and bit 2, 1 and 0 of x at weights 16, 4, 1.
- R8: `px_off` = row*S + col*B. B is 4, 8 or 1 for format codes 0, 1 and 2. S is width*B rounded up to a multiple of 64.
- R9: In read mode a packed pixel is presented only after both of its responses have arrived. It stays valid and stable until `out_ready`.
- R10: In write mode, after a pixel is accepted, `in_ready` stays low until that pixel's depth write (if any) and stencil write have both been accepted.
- R11: A job covers exactly width*height pixels in raster order. `done` pulses exactly once at the end, with `busy` already low.
- R12: After reset the engine is idle. `busy`, `in_ready`, `out_valid`, `dreq_valid` and `sreq_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a job when idle |
| cfg_wr | input | 1 | 1: stream to memory (split); 0: memory to stream (merge) |
| cfg_fmt | input | 2 | 0: 24-bit depth, 1: 32-bit float depth, 2/3: stencil only |
| cfg_width | input | DIM_W | Pixels per row (at least 1) |
| cfg_height | input | DIM_W | Rows (at least 1) |
| cfg_d_base | input | ADDR_W | Depth surface base address |
| cfg_d_tpr | input | TPR_W | Depth surface tiles per row |
| cfg_s_base | input | ADDR_W | Stencil surface base address |
| cfg_s_tpr | input | TPR_W | Stencil surface tiles per row |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse at job end |
| px_off | output | ADDR_W | Packed-buffer byte offset of the current pixel |
| in_valid | input | 1 | Packed pixel offered (write mode) |
| in_ready | output | 1 | Engine takes a packed pixel |
| in_data | input | 64 | Packed pixel in |
| out_valid | output | 1 | Packed pixel offered (read mode) |
| out_ready | input | 1 | Sink takes the packed pixel |
| out_data | output | 64 | Packed pixel out |
| dreq_valid | output | 1 | Depth request valid |
| dreq_ready | input | 1 | Depth request accepted |
| dreq_we | output | 1 | Depth request is a write |
| dreq_addr | output | ADDR_W | Depth byte address |
| dreq_wdata | output | 32 | Depth write data |
| dreq_be | output | 4 | Depth write byte enables |
| drsp_valid | input | 1 | Depth read data valid |
| drsp_data | input | 32 | Depth read data |
| sreq_valid | output | 1 | Stencil request valid |
| sreq_ready | input | 1 | Stencil request accepted |
| sreq_we | output | 1 | Stencil request is a write |
| sreq_addr | output | ADDR_W | Stencil byte address |
| sreq_wdata | output | 8 | Stencil write data |
| srsp_valid | input | 1 | Stencil read data valid |
| srsp_data | input | 8 | Stencil read data |

## Verification
The bench drives rectangles that cross Y-major tile edges (byte x past 128, rows past 32) and W-major tile edges (x and rows past 64). An address unit with a wrong shift or a swapped interleave bit would send requests to addresses the scoreboard does not expect. Stencil responses are made slower than depth responses, and sink and memory stalls are applied. An engine that emitted a pixel on the first response alone would show a stale stencil byte. An engine that took the next pixel early would be caught by the per-pixel write counts. Packed-stream offsets are checked with widths whose byte count is not a multiple of 64, which exposes a missing row-stride round-up. The stencil-only jobs count depth requests, which must stay at zero.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [1:0] {
    FMT_D24S8  = 2'd0,
    FMT_D32FS8 = 2'd1,
    FMT_S8     = 2'd2,
    FMT_S8ALT  = 2'd3
  } dsp_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TAKE,
    ST_XFER,
    ST_EMIT
  } dsp_state_e;

  // log2 of packed bytes per pixel
  function automatic logic [1:0] pix_shift(dsp_fmt_e f);
    case (f)
      FMT_D24S8:  return 2'd2;
      FMT_D32FS8: return 2'd3;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic has_depth(dsp_fmt_e f);
    return (f == FMT_D24S8) || (f == FMT_D32FS8);
  endfunction

endpackage

// File: rtl/dsp_tile_addr.sv
module dsp_tile_addr #(
  parameter int ADDR_W = 32,
  parameter int X_W    = 10,
  parameter int Y_W    = 8,
  parameter int TPR_W  = 8,
  parameter int MAJOR  = 0   // 0: Y-major 4 KiB tile, 1: W-major 4 KiB tile
) (
  input  logic [X_W-1:0]    xb,
  input  logic [Y_W-1:0]    y,
  input  logic [TPR_W-1:0]  tpr,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);

  localparam int TILE_SH = 12;

  logic [ADDR_W-1:0] tile;
  logic [11:0]       inner;

  generate
    if (MAJOR == 0) begin : g_ymaj
      // 128-byte wide, 32-row tile; 16-byte columns stacked down the tile
      assign tile  = ADDR_W'(y >> 5) * ADDR_W'(tpr) + ADDR_W'(xb >> 7);
      assign inner = {xb[6:4], y[4:0], xb[3:0]};
    end else begin : g_wmaj
      // 64x64 byte tile; 8x8 blocks column-major, then 4x4/2x2/1x1 row-major
      assign tile  = ADDR_W'(y >> 6) * ADDR_W'(tpr) + ADDR_W'(xb >> 6);
      assign inner = {xb[5:3], y[5:3], y[2], xb[2], y[1], xb[1], y[0], xb[0]};
    end
  endgenerate

  assign addr = base + ((tile << TILE_SH) | ADDR_W'(inner));

endmodule

// File: rtl/dsp_raster.sv
module dsp_raster #(
  parameter int DIM_W = 8,
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [1:0]       shift,
  output logic [DIM_W-1:0] col,
  output logic [DIM_W-1:0] row,
  output logic [OFF_W-1:0] off,
  output logic             last
);

  localparam logic [DIM_W-1:0] ONE   = DIM_W'(1);
  localparam logic [OFF_W-1:0] ALIGN = OFF_W'(63);

  logic [DIM_W-1:0] col_q, col_d, row_q, row_d;
  logic [OFF_W-1:0] roff_q, roff_d;
  logic [OFF_W-1:0] row_bytes, stride;
  logic             row_end;

  assign row_bytes = OFF_W'(width) << shift;
  assign stride    = (row_bytes + ALIGN) & ~ALIGN;
  assign row_end   = (col_q == width - ONE);

  always_comb begin
    col_d  = col_q;
    row_d  = row_q;
    roff_d = roff_q;
    if (start) begin
      col_d  = '0;
      row_d  = '0;
      roff_d = '0;
    end else if (step) begin
      if (row_end) begin
        col_d  = '0;
        row_d  = row_q + ONE;
        roff_d = roff_q + stride;
      end else begin
        col_d  = col_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      roff_q <= '0;
    end else if (start || step) begin
      col_q  <= col_d;
      row_q  <= row_d;
      roff_q <= roff_d;
    end
  end

  assign col  = col_q;
  assign row  = row_q;
  assign off  = roff_q + (OFF_W'(col_q) << shift);
  assign last = row_end && (row_q == height - ONE);

endmodule

// File: rtl/dsp_pack_engine.sv
module dsp_pack_engine
  import dsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 8,
  parameter int TPR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_fmt,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [ADDR_W-1:0] cfg_d_base,
  input  logic [TPR_W-1:0]  cfg_d_tpr,
  input  logic [ADDR_W-1:0] cfg_s_base,
  input  logic [TPR_W-1:0]  cfg_s_tpr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] px_off,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_data,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic              dreq_we,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [31:0]       dreq_wdata,
  output logic [3:0]        dreq_be,
  input  logic              drsp_valid,
  input  logic [31:0]       drsp_data,
  output logic              sreq_valid,
  input  logic              sreq_ready,
  output logic              sreq_we,
  output logic [ADDR_W-1:0] sreq_addr,
  output logic [7:0]        sreq_wdata,
  input  logic              srsp_valid,
  input  logic [7:0]        srsp_data
);

  localparam int XB_W = DIM_W + 2;   // depth x in bytes (4 bytes per pixel)

  dsp_state_e        state_q, state_d;
  dsp_fmt_e          fmt_q;
  logic              wr_q;
  logic [DIM_W-1:0]  w_q, h_q;
  logic [ADDR_W-1:0] dbase_q, sbase_q;
  logic [TPR_W-1:0]  dtpr_q, stpr_q;
  logic [63:0]       pix_q, pix_d;
  logic [31:0]       dd_q, dd_d;
  logic [7:0]        sd_q, sd_d;
  logic              d_sent_q, d_sent_d, s_sent_q, s_sent_d;
  logic              d_have_q, d_have_d, s_have_q, s_have_d;
  logic              done_q, done_d;

  logic              cfg_en, step, last, need_d, d_fin, s_fin;
  logic [DIM_W-1:0]  col, row;

  assign cfg_en = (state_q == ST_IDLE) && start;
  assign need_d = has_depth(fmt_q);
  assign d_fin  = !need_d || (wr_q ? d_sent_q : d_have_q);
  assign s_fin  = wr_q ? s_sent_q : s_have_q;

  dsp_raster #(.DIM_W(DIM_W), .OFF_W(ADDR_W)) u_raster (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cfg_en),
    .step   (step),
    .width  (w_q),
    .height (h_q),
    .shift  (pix_shift(fmt_q)),
    .col    (col),
    .row    (row),
    .off    (px_off),
    .last   (last)
  );

  dsp_tile_addr #(.ADDR_W(ADDR_W), .X_W(XB_W), .Y_W(DIM_W), .TPR_W(TPR_W), .MAJOR(0)) u_daddr (
    .xb   ({col, 2'b00}),
    .y    (row),
    .tpr  (dtpr_q),
    .base (dbase_q),
    .addr (dreq_addr)
  );

  dsp_tile_addr #(.ADDR_W(ADDR_W), .X_W(DIM_W), .Y_W(DIM_W), .TPR_W(TPR_W), .MAJOR(1)) u_saddr (
    .xb   (col),
    .y    (row),
    .tpr  (stpr_q),
    .base (sbase_q),
    .addr (sreq_addr)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    pix_d    = pix_q;
    dd_d     = dd_q;
    sd_d     = sd_q;
    d_sent_d = d_sent_q;
    s_sent_d = s_sent_q;
    d_have_d = d_have_q;
    s_have_d = s_have_q;
    done_d   = 1'b0;
    step     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = cfg_wr ? ST_TAKE : ST_XFER;
          d_sent_d = 1'b0; s_sent_d = 1'b0;
          d_have_d = 1'b0; s_have_d = 1'b0;
        end
      end
      ST_TAKE: begin
        if (in_valid) begin
          pix_d    = in_data;
          state_d  = ST_XFER;
          d_sent_d = 1'b0; s_sent_d = 1'b0;
        end
      end
      ST_XFER: begin
        if (dreq_valid && dreq_ready) d_sent_d = 1'b1;
        if (sreq_valid && sreq_ready) s_sent_d = 1'b1;
        if (!wr_q && d_sent_q && !d_have_q && drsp_valid) begin
          d_have_d = 1'b1;
          dd_d     = drsp_data;
        end
        if (!wr_q && s_sent_q && !s_have_q && srsp_valid) begin
          s_have_d = 1'b1;
          sd_d     = srsp_data;
        end
        if (d_fin && s_fin) begin
          if (wr_q) begin
            step    = 1'b1;
            state_d = last ? ST_IDLE : ST_TAKE;
            done_d  = last;
          end else begin
            state_d = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          step     = 1'b1;
          state_d  = last ? ST_IDLE : ST_XFER;
          done_d   = last;
          d_sent_d = 1'b0; s_sent_d = 1'b0;
          d_have_d = 1'b0; s_have_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      d_sent_q <= 1'b0;
      s_sent_q <= 1'b0;
      d_have_q <= 1'b0;
      s_have_q <= 1'b0;
      done_q   <= 1'b0;
      fmt_q    <= FMT_D24S8;
      wr_q     <= 1'b0;
      w_q      <= '0;
      h_q      <= '0;
      dbase_q  <= '0;
      sbase_q  <= '0;
      dtpr_q   <= '0;
      stpr_q   <= '0;
    end else begin
      state_q  <= state_d;
      d_sent_q <= d_sent_d;
      s_sent_q <= s_sent_d;
      d_have_q <= d_have_d;
      s_have_q <= s_have_d;
      done_q   <= done_d;
      if (cfg_en) begin
        fmt_q   <= dsp_fmt_e'(cfg_fmt);
        wr_q    <= cfg_wr;
        w_q     <= cfg_width;
        h_q     <= cfg_height;
        dbase_q <= cfg_d_base;
        sbase_q <= cfg_s_base;
        dtpr_q  <= cfg_d_tpr;
        stpr_q  <= cfg_s_tpr;
      end
    end
  end

  always_ff @(posedge clk) begin
    pix_q <= pix_d;
    dd_q  <= dd_d;
    sd_q  <= sd_d;
  end

  // outputs
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign in_ready  = (state_q == ST_TAKE);
  assign out_valid = (state_q == ST_EMIT);

  always_comb begin
    case (fmt_q)
      FMT_D24S8:  out_data = {32'h0, sd_q, dd_q[23:0]};
      FMT_D32FS8: out_data = {24'h0, sd_q, dd_q};
      default:    out_data = {56'h0, sd_q};
    endcase
  end

  assign dreq_valid = (state_q == ST_XFER) && need_d && !d_sent_q;
  assign dreq_we    = wr_q;
  assign dreq_wdata = (fmt_q == FMT_D32FS8) ? pix_q[31:0] : {8'h00, pix_q[23:0]};
  assign dreq_be    = (fmt_q == FMT_D32FS8) ? 4'b1111 : 4'b0111;

  assign sreq_valid = (state_q == ST_XFER) && !s_sent_q;
  assign sreq_we    = wr_q;

  always_comb begin
    case (fmt_q)
      FMT_D24S8:  sreq_wdata = pix_q[31:24];
      FMT_D32FS8: sreq_wdata = pix_q[39:32];
      default:    sreq_wdata = pix_q[7:0];
    endcase
  end

endmodule

// File: rtl/dsp_pack_chk.sv
module dsp_pack_chk
  import dsp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [63:0]       out_data,
  input logic              dreq_valid,
  input logic              dreq_ready,
  input logic [ADDR_W-1:0] dreq_addr,
  input logic              sreq_valid,
  input logic              sreq_ready,
  input logic [ADDR_W-1:0] sreq_addr,
  input dsp_fmt_e          fmt_q
);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready && !dreq_valid && !sreq_valid));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  one_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R10
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, out_valid}));

  // R5
  s8_nodepth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !has_depth(fmt_q)) |-> !dreq_valid);

  // R6
  dreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && !dreq_ready) |=> (dreq_valid && $stable(dreq_addr)));

  // R7
  sreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sreq_valid && !sreq_ready) |=> (sreq_valid && $stable(sreq_addr)));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind dsp_pack_engine dsp_pack_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .dreq_valid (dreq_valid),
  .dreq_ready (dreq_ready),
  .dreq_addr  (dreq_addr),
  .sreq_valid (sreq_valid),
  .sreq_ready (sreq_ready),
  .sreq_addr  (sreq_addr),
  .fmt_q      (fmt_q)
);

// File: tb/dsp_pack_engine_tb.sv
`timescale 1ns/1ps
module dsp_pack_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cfg_wr = 1'b0;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [7:0]  cfg_width = 8'd1, cfg_height = 8'd1, cfg_d_tpr = 8'd1, cfg_s_tpr = 8'd1;
  logic [31:0] cfg_d_base = 32'h0010_0000, cfg_s_base = 32'h0080_0000;
  logic        busy, done, in_ready, out_valid, dreq_valid, dreq_we, sreq_valid, sreq_we;
  logic [31:0] px_off, dreq_addr, dreq_wdata, sreq_addr;
  logic [63:0] out_data;
  logic [3:0]  dreq_be;
  logic [7:0]  sreq_wdata;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic        dreq_ready = 1'b0, sreq_ready = 1'b0, drsp_valid = 1'b0, srsp_valid = 1'b0;
  logic [31:0] drsp_data = '0;
  logic [7:0]  srsp_data = '0;

  always #5 clk = ~clk;

  dsp_pack_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_d_base(cfg_d_base),
    .cfg_d_tpr(cfg_d_tpr), .cfg_s_base(cfg_s_base), .cfg_s_tpr(cfg_s_tpr),
    .busy(busy), .done(done), .px_off(px_off),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_we(dreq_we),
    .dreq_addr(dreq_addr), .dreq_wdata(dreq_wdata), .dreq_be(dreq_be),
    .drsp_valid(drsp_valid), .drsp_data(drsp_data),
    .sreq_valid(sreq_valid), .sreq_ready(sreq_ready), .sreq_we(sreq_we),
    .sreq_addr(sreq_addr), .sreq_wdata(sreq_wdata),
    .srsp_valid(srsp_valid), .srsp_data(srsp_data)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int dlat = 0, slat = 0, d_tmr = 0, s_tmr = 0;
  bit stall = 1'b0;
  int d_req_cnt = 0, d_wr_cnt = 0, s_wr_cnt = 0, acc_cnt = 0, done_cnt = 0;
  bit job_has_d = 1'b1;

  logic [95:0] exp_out_q[$];   // {off, data}
  logic [67:0] exp_dw_q[$];    // {addr, data, be}
  logic [39:0] exp_sw_q[$];    // {addr, data}
  logic [31:0] d_pend[$], s_pend[$];

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] dval(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [7:0] sval(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic int yoff(int xb, int y, int tpr);
    return ((y / 32) * tpr + xb / 128) * 4096 + ((xb % 128) / 16) * 512 + (y % 32) * 16 + xb % 16;
  endfunction
  function automatic int woff(int x, int y, int tpr);
    return ((y / 64) * tpr + x / 64) * 4096 + ((x % 64) / 8) * 512 + ((y % 64) / 8) * 64
         + ((y / 4) % 2) * 32 + ((x / 4) % 2) * 16 + ((y / 2) % 2) * 8 + ((x / 2) % 2) * 4
         + (y % 2) * 2 + (x % 2);
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // memory models and stream sink: drive just after the edge
  always @(posedge clk) begin
    #1;
    dreq_ready = !stall || (cyc % 3 != 0);
    sreq_ready = !stall || (cyc % 4 != 1);
    out_ready  = !stall || (cyc % 2 == 0);
    drsp_valid = 1'b0;
    srsp_valid = 1'b0;
    if (d_pend.size() > 0) begin
      if (d_tmr >= dlat) begin
        drsp_valid = 1'b1; drsp_data = dval(d_pend.pop_front()); d_tmr = 0;
      end else d_tmr++;
    end
    if (s_pend.size() > 0) begin
      if (s_tmr >= slat) begin
        srsp_valid = 1'b1; srsp_data = sval(s_pend.pop_front()); s_tmr = 0;
      end else s_tmr++;
    end
  end

  // scoreboard monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (out_valid && out_ready) begin
        if (exp_out_q.size() == 0) chk(1'b0, "R11 unexpected output pixel", out_data, 0);
        else begin
          logic [95:0] e;
          e = exp_out_q.pop_front();
          chk(out_data == e[63:0], "R1/R2/R5/R9 packed pixel data", out_data, e[63:0]);
          chk(px_off == e[95:64], "R8 packed offset", px_off, e[95:64]);
        end
      end
      if (in_valid && in_ready) begin
        chk(d_wr_cnt == acc_cnt * (job_has_d ? 1 : 0) && s_wr_cnt == acc_cnt,
            "R10 writes done before next pixel", {d_wr_cnt, s_wr_cnt}, {acc_cnt, acc_cnt});
        acc_cnt++;
      end
      if (dreq_valid && dreq_ready) begin
        d_req_cnt++;
        if (dreq_we) begin
          d_wr_cnt++;
          if (exp_dw_q.size() == 0) chk(1'b0, "R11 unexpected depth write", dreq_addr, 0);
          else begin
            logic [67:0] e;
            e = exp_dw_q.pop_front();
            chk({dreq_addr, dreq_wdata, dreq_be} == e, "R3/R4/R6 depth write",
                {dreq_addr, dreq_wdata, dreq_be}, e);
          end
        end else begin
          d_pend.push_back(dreq_addr);
        end
      end
      if (sreq_valid && sreq_ready) begin
        if (sreq_we) begin
          s_wr_cnt++;
          if (exp_sw_q.size() == 0) chk(1'b0, "R11 unexpected stencil write", sreq_addr, 0);
          else begin
            logic [39:0] e;
            e = exp_sw_q.pop_front();
            chk({sreq_addr, sreq_wdata} == e, "R3/R4/R5/R7 stencil write", {sreq_addr, sreq_wdata}, e);
          end
        end else begin
          s_pend.push_back(sreq_addr);
        end
      end
    end
  end

  task automatic run_job(input bit wr, input logic [1:0] fmt, input int w, input int h,
                         input int dtpr, input int stpr, input int dl, input int sl, input bit st);
    logic [63:0] drv_q[$];
    int sh, stride, t;
    logic [31:0] da, sa, dbase, sbase;
    dbase = 32'h0010_0000;
    sbase = 32'h0080_0000;
    sh = (fmt == 2'd0) ? 2 : (fmt == 2'd1) ? 3 : 0;
    stride = (((w << sh) + 63) / 64) * 64;
    dlat = dl; slat = sl; stall = st;
    d_req_cnt = 0; d_wr_cnt = 0; s_wr_cnt = 0; acc_cnt = 0; done_cnt = 0;
    job_has_d = (fmt < 2'd2);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        logic [63:0] p, e;
        da = dbase + 32'(yoff(c * 4, r, dtpr));
        sa = sbase + 32'(woff(c, r, stpr));
        if (!wr) begin
          if (fmt == 2'd0)      e = {32'h0, sval(sa), dval(da)[23:0]};
          else if (fmt == 2'd1) e = {24'h0, sval(sa), dval(da)};
          else                  e = {56'h0, sval(sa)};
          exp_out_q.push_back({32'(r * stride + (c << sh)), e});
        end else begin
          p = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(r * w + c + 1) * 64'h0101_0101_0101_0101);
          drv_q.push_back(p);
          if (fmt == 2'd0) begin
            exp_dw_q.push_back({da, 8'h00, p[23:0], 4'b0111});
            exp_sw_q.push_back({sa, p[31:24]});
          end else if (fmt == 2'd1) begin
            exp_dw_q.push_back({da, p[31:0], 4'b1111});
            exp_sw_q.push_back({sa, p[39:32]});
          end else begin
            exp_sw_q.push_back({sa, p[7:0]});
          end
        end
      end
    end
    @(posedge clk); #1;
    cfg_wr = wr; cfg_fmt = fmt; cfg_width = 8'(w); cfg_height = 8'(h);
    cfg_d_tpr = 8'(dtpr); cfg_s_tpr = 8'(stpr); cfg_d_base = dbase; cfg_s_base = sbase;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (wr) begin
      while (drv_q.size() > 0) begin
        in_valid = 1'b1;
        in_data  = drv_q.pop_front();
        forever begin
          @(negedge clk);
          if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
      end
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin
      @(negedge clk); #1;
      t++;
    end
    repeat (4) @(negedge clk);
    #1;
    chk(done_cnt == 1, "R11 one done pulse per job", done_cnt, 1);
    chk(busy == 1'b0, "R11 idle after job", busy, 0);
    chk(exp_out_q.size() == 0 && exp_dw_q.size() == 0 && exp_sw_q.size() == 0,
        "R11 all pixels of the job handled",
        exp_out_q.size() + exp_dw_q.size() + exp_sw_q.size(), 0);
    if (fmt >= 2'd2) chk(d_req_cnt == 0, "R5 no depth access in stencil-only", d_req_cnt, 0);
    exp_out_q.delete(); exp_dw_q.delete(); exp_sw_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !in_ready && !out_valid && !dreq_valid && !sreq_valid,
        "R12 quiet in reset", {busy, in_ready, out_valid, dreq_valid, sreq_valid}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !in_ready && !out_valid && !dreq_valid && !sreq_valid,
        "R12 idle after reset", {busy, in_ready, out_valid, dreq_valid, sreq_valid}, 0);

    // R1 R6 R7 R8 R9: 24-bit depth merge, slow stencil, stalls
    run_job(1'b0, 2'd0, 5, 3, 2, 1, 0, 3, 1'b1);
    // R2: 32-bit float depth merge, slow depth
    run_job(1'b0, 2'd1, 3, 2, 1, 1, 4, 0, 1'b0);
    // R6 R7: crosses Y-major x edge (byte 128) and W-major x edge (64)
    run_job(1'b0, 2'd0, 70, 2, 3, 2, 1, 2, 1'b1);
    // R6 R7: crosses Y-major row edge (32) and W-major row edge (64)
    run_job(1'b0, 2'd1, 2, 66, 1, 1, 0, 1, 1'b0);
    // R3 R10: 24-bit depth split with stalls
    run_job(1'b1, 2'd0, 4, 2, 1, 1, 0, 0, 1'b1);
    // R4 R10: 32-bit float depth split
    run_job(1'b1, 2'd1, 3, 3, 1, 1, 0, 0, 1'b0);
    // R5: stencil-only merge and split
    run_job(1'b0, 2'd2, 9, 2, 1, 1, 2, 1, 1'b1);
    run_job(1'b1, 2'd2, 5, 1, 1, 1, 0, 0, 1'b1);
    // R5: code 3 behaves as stencil-only
    run_job(1'b0, 2'd3, 3, 1, 1, 1, 0, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule